// File: doc/BRIEF.md
# Serial Register Access Port

This block lets a serial test port reach a bank of 32-bit registers through one 40-bit shift chain. Each scan loads the chain, shifts a new command in through `tdi` while the old contents leave through `tdo`, and then executes the command. A command holds a 32-bit data word, a 7-bit register address and a direction flag. A write goes straight to the register bank. A read issues a one-cycle read strobe and keeps the returned word, and the next scan shifts that word out.

Reads are therefore pipelined by one scan. The word seen in a scan belongs to the address given in the scan before it. Some registers have side effects when read, such as a data window that advances an internal pointer on every strobe. For such a register, every scan that addresses it consumes one entry. A run of reads should end with a dummy scan to a register that has no side effects, such as address 0. The capture, shift and update strobes come from an external test-port controller, and all of them are qualifiers on the test clock.

Top module: `scan_regport`

## Requirements
- R1: After reset, `tdo`, `rf_we`, `rf_re`, `rf_addr` and `rf_wdata` are 0, and the first scan shifts out an all-zero chain.
- R2: The chain is 40 bits: bits 31:0 data, bits 38:32 address, bit 39 direction flag (1 = write, 0 = read). `tdo` shows bit 0, and a shift moves `tdi` into bit 39, so data bit 0 is the first bit out and the first bit in.
- R3: A capture loads the held read word into bits 31:0 and zeros into bits 39:32.
- R4: An update whose flag is 1 drives `rf_addr` and `rf_wdata` from the chain and raises `rf_we` for exactly one cycle, in the cycle after the update edge.
- R5: An update whose flag is 0 drives `rf_addr` from the chain and raises `rf_re` for exactly one cycle. `rf_we` stays low and `rf_wdata` is unchanged.
- R6: `rf_rdata` is sampled at the end of the `rf_re` cycle, and the next scan shifts it out. A write scan leaves the held word unchanged.
- R7: Consecutive read scans of the same address each raise `rf_re` once. A pointer-advancing register therefore yields successive entries, one scan late, and a trailing read of address 0 returns the last entry without skipping any.
- R8: Strobe priority is capture over shift over update. An update asserted in the same cycle as capture or shift does nothing.
- R9: An update that follows a capture with no shift between them performs a read of address 0.
- R10: No register strobe occurs outside a valid update, and the chain holds its value in any cycle without capture or shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tdi | input | 1 | Serial data into chain bit 39 |
| tdo | output | 1 | Serial data from chain bit 0 |
| capture_en | input | 1 | Load chain from held read word |
| shift_en | input | 1 | Shift chain one bit toward bit 0 |
| update_en | input | 1 | Execute command held in chain |
| rf_addr | output | 7 | Register bank address |
| rf_wdata | output | 32 | Register bank write data |
| rf_we | output | 1 | One-cycle write strobe |
| rf_re | output | 1 | One-cycle read strobe |
| rf_rdata | input | 32 | Register bank read data, valid while rf_re is high |

## Verification
The bench runs runs of reads on a pointer-advancing register, then a dummy read. A design that returned data in the same scan, or that strobed twice per scan, would show a shifted or skipped sequence. Colliding strobes (capture with shift, shift with update, capture with update) would expose a wrong priority: the captured word would come out misaligned by one bit, or a spurious bank strobe would appear. An update straight after a capture must read address 0; a design that left stale address bits in the chain would strobe some other register. Random mixes of reads and writes show whether a write wrongly overwrites the held read word.

// File: rtl/scan_regport_pkg.sv
package scan_regport_pkg;

  parameter int unsigned DATA_W_DFLT = 32;
  parameter int unsigned ADDR_W_DFLT = 7;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;

  function automatic acc_e acc_of(input logic flag);
    return flag ? ACC_WRITE : ACC_READ;
  endfunction

endpackage

// File: rtl/scan_shreg.sv
module scan_shreg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_i,
  input  logic                     shift_i,
  input  logic                     tdi_i,
  input  logic [DATA_W-1:0]        cap_data_i,
  output logic [DATA_W+ADDR_W:0]   chain_o,
  output logic                     tdo_o
);
  localparam int unsigned CW  = DATA_W + ADDR_W + 1;
  localparam int unsigned HDR = ADDR_W + 1;

  logic shift_evt;
  assign shift_evt = shift_i & ~cap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_o <= '0;
    end else if (cap_i) begin
      chain_o <= {{HDR{1'b0}}, cap_data_i};
    end else if (shift_evt) begin
      chain_o <= {tdi_i, chain_o[CW-1:1]};
    end
  end

  assign tdo_o = chain_o[0];

  // R3: capture fills data from held word, header zero
  p_capture_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (chain_o[CW-1:DATA_W] == '0) && (chain_o[DATA_W-1:0] == $past(cap_data_i)));

  // R2: tdi enters at the top, everything moves one place toward bit 0
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (chain_o[CW-1] == $past(tdi_i)) && (chain_o[CW-2:0] == $past(chain_o[CW-1:1])));

  // R10: chain idles when neither capture nor shift
  p_chain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && !shift_i) |=> $stable(chain_o));

endmodule

// File: rtl/scan_upd_ctrl.sv
module scan_upd_ctrl
  import scan_regport_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_i,
  input  logic                   cap_i,
  input  logic                   shift_i,
  input  logic [DATA_W+ADDR_W:0] chain_i,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic                   we_o,
  output logic                   re_o
);
  localparam int unsigned CW       = DATA_W + ADDR_W + 1;
  localparam int unsigned FLAG_POS = CW - 1;
  localparam int unsigned ADDR_LO  = DATA_W;

  logic              upd_fire;
  acc_e              acc_req;
  logic [ADDR_W-1:0] addr_fld;
  logic [DATA_W-1:0] data_fld;

  assign upd_fire = upd_i & ~cap_i & ~shift_i;
  assign acc_req  = acc_of(chain_i[FLAG_POS]);
  assign addr_fld = chain_i[ADDR_LO +: ADDR_W];
  assign data_fld = chain_i[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      re_o    <= 1'b0;
    end else begin
      we_o <= 1'b0;
      re_o <= 1'b0;
      if (upd_fire) begin
        addr_o <= addr_fld;
        if (acc_req == ACC_WRITE) begin
          wdata_o <= data_fld;
          we_o    <= 1'b1;
        end else begin
          re_o <= 1'b1;
        end
      end
    end
  end

  // R5: read and write strobes are never together
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_o && re_o));

  // R4: write strobe only after a valid update with flag set, carrying its fields
  p_write_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> ($past(upd_fire) && $past(chain_i[FLAG_POS]) &&
              addr_o == $past(chain_i[ADDR_LO +: ADDR_W]) &&
              wdata_o == $past(chain_i[DATA_W-1:0])));

  // R5: read strobe only after a valid update with flag clear
  p_read_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    re_o |-> ($past(upd_fire) && !$past(chain_i[FLAG_POS]) &&
              addr_o == $past(chain_i[ADDR_LO +: ADDR_W])));

  // R8 / R10: no strobe without a fired update
  p_no_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> (!we_o && !re_o));

  // R5: a read leaves the write data alone
  p_wdata_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_o |-> $stable(wdata_o));

endmodule

// File: rtl/scan_rd_hold.sv
module scan_rd_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] hold_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= '0;
    end else if (re_i) begin
      hold_o <= rdata_i;
    end
  end

  // R6: word returned during the strobe cycle is kept
  p_hold_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    re_i |=> hold_o == $past(rdata_i));

  // R6: held word only changes on a read strobe
  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_i |=> $stable(hold_o));

endmodule

// File: rtl/scan_regport.sv
module scan_regport
  import scan_regport_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DFLT,
  parameter int unsigned ADDR_W = ADDR_W_DFLT
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tdi,
  output logic              tdo,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int unsigned CW = DATA_W + ADDR_W + 1;

  logic [CW-1:0]     chain;
  logic [DATA_W-1:0] held_word;

  scan_shreg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shreg (
    .clk        (tck),
    .rst_n      (rst_n),
    .cap_i      (capture_en),
    .shift_i    (shift_en),
    .tdi_i      (tdi),
    .cap_data_i (held_word),
    .chain_o    (chain),
    .tdo_o      (tdo)
  );

  scan_upd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (tck),
    .rst_n   (rst_n),
    .upd_i   (update_en),
    .cap_i   (capture_en),
    .shift_i (shift_en),
    .chain_i (chain),
    .addr_o  (rf_addr),
    .wdata_o (rf_wdata),
    .we_o    (rf_we),
    .re_o    (rf_re)
  );

  scan_rd_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (tck),
    .rst_n   (rst_n),
    .re_i    (rf_re),
    .rdata_i (rf_rdata),
    .hold_o  (held_word)
  );

  // R1: serial output is the chain bottom bit, zero out of reset
  p_tdo_reset_r1: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(rst_n) |-> (tdo == 1'b0));

endmodule

// File: tb/scan_regport_test.sv
module scan_regport_test;
  localparam logic [31:0] ID_WORD = 32'h5CA7_1D01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tdi = 1'b0;
  logic        capture_en = 1'b0;
  logic        shift_en = 1'b0;
  logic        update_en = 1'b0;
  logic        tdo;
  logic [6:0]  rf_addr;
  logic [31:0] rf_wdata;
  logic        rf_we;
  logic        rf_re;
  logic [31:0] rf_rdata;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  scan_regport uut (
    .tck(clk), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
    .rf_rdata(rf_rdata)
  );

  // register bank environment: addr 0 fixed id, addr 4 pointer window
  logic [31:0] env_regs [128];
  logic [3:0]  env_ptr = 4'd0;
  int we_cnt = 0;
  int re_cnt = 0;
  logic [6:0]  mon_addr;
  logic [31:0] mon_wdata;

  function automatic logic [31:0] win_word(input logic [3:0] p);
    return 32'hA500_0000 + ({28'd0, p} * 32'h0001_0203);
  endfunction

  always_comb begin
    if (rf_addr == 7'd0)      rf_rdata = ID_WORD;
    else if (rf_addr == 7'd4) rf_rdata = win_word(env_ptr);
    else                      rf_rdata = env_regs[rf_addr];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        we_cnt++;
        mon_addr  = rf_addr;
        mon_wdata = rf_wdata;
        if (rf_addr != 7'd0 && rf_addr != 7'd4) env_regs[rf_addr] <= rf_wdata;
      end
      if (rf_re) begin
        re_cnt++;
        mon_addr = rf_addr;
        if (rf_addr == 7'd4) env_ptr <= env_ptr + 4'd1;
      end
    end
  end

  // bench shadow for expected values
  logic [31:0] sh_regs [128];
  logic [3:0]  sh_ptr = 4'd0;
  logic [31:0] exp_hold = 32'd0;

  function automatic logic [31:0] sh_read(input logic [6:0] a);
    if (a == 7'd0) return ID_WORD;
    if (a == 7'd4) return win_word(sh_ptr);
    return sh_regs[a];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // one full scan: capture, 40 shifts, update, idle
  task automatic do_scan(input logic flag, input logic [6:0] a,
                         input logic [31:0] d, output logic [39:0] got);
    logic [39:0] vec;
    vec = {flag, a, d};
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (i > 0) @(negedge clk);
      got[i]   = tdo;
      tdi      = vec[i];
      shift_en = 1'b1;
    end
    @(negedge clk) shift_en = 1'b0; update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic scan_check(input string req, input logic flag,
                            input logic [6:0] a, input logic [31:0] d);
    logic [39:0] got;
    int we0, re0;
    logic [31:0] wd0;
    we0 = we_cnt; re0 = re_cnt; wd0 = rf_wdata;
    do_scan(flag, a, d, got);
    chk(req, "R3 captured data", {32'd0, got[31:0]}, {32'd0, exp_hold});
    chk(req, "R3 captured header", {56'd0, got[39:32]}, 64'd0);
    if (flag) begin
      chk(req, "R4 write strobes", we_cnt - we0, 1);
      chk(req, "R4 read strobes", re_cnt - re0, 0);
      chk(req, "R4 write addr", {57'd0, mon_addr}, {57'd0, a});
      chk(req, "R4 write data", {32'd0, mon_wdata}, {32'd0, d});
      if (a != 7'd0 && a != 7'd4) sh_regs[a] = d;
    end else begin
      chk(req, "R5 read strobes", re_cnt - re0, 1);
      chk(req, "R5 write strobes", we_cnt - we0, 0);
      chk(req, "R5 read addr", {57'd0, mon_addr}, {57'd0, a});
      chk(req, "R5 wdata kept", {32'd0, rf_wdata}, {32'd0, wd0});
      exp_hold = sh_read(a);
      if (a == 7'd4) sh_ptr = sh_ptr + 4'd1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [39:0] got;
    int we0, re0;
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 128; i++) begin
      env_regs[i] = 32'd0;
      sh_regs[i]  = 32'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tdo", {63'd0, tdo}, 0);
    chk("R1", "we", {63'd0, rf_we}, 0);
    chk("R1", "re", {63'd0, rf_re}, 0);
    chk("R1", "addr", {57'd0, rf_addr}, 0);
    chk("R1", "wdata", {32'd0, rf_wdata}, 0);

    // R1/R2/R4: first scan writes and shifts out zeros
    scan_check("R1", 1'b1, 7'd9, 32'h1357_9BDF);
    // R2/R5/R6: read back pipelined by one scan
    scan_check("R2", 1'b0, 7'd9, 32'hFFFF_FFFF);
    scan_check("R6", 1'b1, 7'd10, 32'h8000_0001);
    scan_check("R6", 1'b0, 7'd10, 32'd0);
    scan_check("R6", 1'b0, 7'd0, 32'd0);

    // R7: run of pointer reads with trailing dummy
    for (int k = 0; k < 5; k++) scan_check("R7", 1'b0, 7'd4, 32'd0);
    scan_check("R7", 1'b0, 7'd0, 32'd0);
    scan_check("R7", 1'b0, 7'd4, 32'd0);
    scan_check("R7", 1'b0, 7'd0, 32'd0);

    // R8: capture wins over shift
    scan_check("R8", 1'b1, 7'd7, 32'h0F1E_2D3C);
    scan_check("R8", 1'b0, 7'd7, 32'd0);
    we0 = we_cnt; re0 = re_cnt;
    @(negedge clk) capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
    @(negedge clk) capture_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (i > 0) @(negedge clk);
      got[i] = tdo;
      tdi    = 1'b0;
    end
    @(negedge clk) shift_en = 1'b0;
    @(negedge clk);
    chk("R8", "capture over shift", {24'd0, got}, {32'd0, exp_hold});
    // R8: update together with shift or capture does nothing
    @(negedge clk) shift_en = 1'b1; update_en = 1'b1; tdi = 1'b1;
    @(negedge clk) shift_en = 1'b0; update_en = 1'b0;
    @(negedge clk) capture_en = 1'b1; update_en = 1'b1;
    @(negedge clk) capture_en = 1'b0; update_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8", "no write strobe", we_cnt - we0, 0);
    chk("R10", "no read strobe", re_cnt - re0, 0);

    // R9: update straight after capture reads address 0
    @(negedge clk) capture_en = 1'b1;
    @(negedge clk) capture_en = 1'b0; update_en = 1'b1;
    @(negedge clk) update_en = 1'b0;
    chk("R9", "read strobe", {63'd0, rf_re}, 1);
    chk("R9", "read addr", {57'd0, rf_addr}, 0);
    @(negedge clk);
    exp_hold = ID_WORD;
    scan_check("R9", 1'b0, 7'd3, 32'd0);

    // random mix
    for (int n = 0; n < 180; n++) begin
      logic [6:0] a;
      logic fl;
      int sel;
      sel = int'($urandom % 4);
      fl  = 1'($urandom % 2);
      if (sel == 0)      a = 7'd0;
      else if (sel == 1) a = 7'd4;
      else begin
        a = 7'($urandom_range(1, 127));
        if (a == 7'd4) a = 7'd5;
      end
      scan_check("R6", fl, a, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule